// File: doc/BRIEF.md
# Prescaled Dual 8-bit Interval Timer

This block is a pair of 8-bit up counters driven from one shared prescaler. A 2-bit divider turns the system clock into a base tick once every four clocks. A 9-bit chain advances on that tick and produces four tap enables whose periods are 8, 32, 128 and 2048 clocks. Every tap is a single-cycle enable in the main clock domain, so no derived clocks are generated. The low counter takes its count from one of three taps or from a synchronized external count input. The high counter takes its count from one of three taps or from the low counter's match pulse.

Each counter compares its value with its own 8-bit compare value. On a hit it raises a one-cycle match pulse, and it returns to zero on the increment after the hit. When the cascade input is set, the high counter counts the low counter's carries instead. The pair then acts as one 16-bit counter, and its match is taken against both compare values joined together. Each counter and the prescaler has its own run input. While that input is low, the counter or prescaler is cleared and stopped.

Top module: `dual_interval_timer`

## Requirements
- R1: While `pre_run` is 1, a base tick occurs once every 4 clocks, and the 9-bit prescaler advances by one on each base tick.
- R2: While `pre_run` is 0, the divider and the prescaler are held at zero and no tap enable fires. A counter that selects a tap therefore stays unchanged.
- R3: The tap enables fire at the base ticks where the prescaler carries out of bit 0, 2, 4 and 8. These give periods of 8, 32, 128 and 2048 clocks (taps T1, T4, T16, T256).
- R4: `clk_sel0` selects the low counter's enable: 00 = external input, 01 = T1, 10 = T4, 11 = T16. On each selected enable the counter advances by exactly one.
- R5: `ext_cnt` passes through two synchronizing flops, and each rising edge yields one enable. The low counter changes at the third rising clock edge after the input rises, and not at the second.
- R6: When `cascade` is 0, `clk_sel1` selects the high counter's enable: 00 = low counter match pulse, 01 = T1, 10 = T16, 11 = T256.
- R7: A counter whose run input is 0 reads zero at the next edge and stays at zero.
- R8: When `cascade` is 0, a counter raises its match output for one cycle after an increment brings it to its compare value. The next increment after that returns it to zero.
- R9: When `cascade` is 1, the high counter advances each time the low counter rolls from 0xFF to 0x00. The match is taken on {count1,count0} against {cmp1,cmp0} and appears on `match1`; `match0` stays 0. The increment after a match clears both bytes.
- R10: While `rst_n` is low, both counters, both match outputs and the prescaler are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pre_run | input | 1 | Prescaler run; 0 clears and stops it |
| run0 | input | 1 | Low counter run; 0 clears and stops it |
| run1 | input | 1 | High counter run; 0 clears and stops it |
| clk_sel0 | input | 2 | Low counter enable select |
| clk_sel1 | input | 2 | High counter enable select (8-bit mode) |
| cascade | input | 1 | 1 joins the counters into one 16-bit counter |
| ext_cnt | input | 1 | Asynchronous external count input |
| cmp0 | input | 8 | Low counter compare value |
| cmp1 | input | 8 | High counter compare value |
| count0 | output | 8 | Low counter value |
| count1 | output | 8 | High counter value |
| match0 | output | 1 | Low counter match pulse |
| match1 | output | 1 | High counter or 16-bit match pulse |

## Verification
A tap-driven increment appears on the counter output at the clock edge where that tap fires. The match pulse is registered, so it appears one edge after the increment that reaches the compare value. An external edge needs three edges to reach the count, and a high counter clocked by the low counter's match lags that match by one more edge. The bench keeps a behavioural model that advances at each rising edge, using the inputs held since the previous falling edge. It compares every output at the falling edge, so each of these latencies is checked at its exact cycle. The period and latency checks also count cycles between falling edges directly.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int PRE_W  = 9;
  localparam int DIV_W  = 2;
  localparam int NTAP   = 4;
  localparam int TAP_POS [NTAP] = '{0, 2, 4, 8};

  typedef enum logic [1:0] {
    LO_EXT = 2'b00,
    LO_T1  = 2'b01,
    LO_T4  = 2'b10,
    LO_T16 = 2'b11
  } lo_sel_e;

  typedef enum logic [1:0] {
    HI_MATCH = 2'b00,
    HI_T1    = 2'b01,
    HI_T16   = 2'b10,
    HI_T256  = 2'b11
  } hi_sel_e;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler
  import dit_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int DW = DIV_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic [NTAP-1:0] tap
);
  logic [DW-1:0] div_q, div_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          base_tick;

  always_comb begin
    base_tick = run && (div_q == '1);
    div_d     = run ? DW'(div_q + 1'b1) : '0;
    if (!run)          pre_d = '0;
    else if (base_tick) pre_d = PW'(pre_q + 1'b1);
    else               pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_d;
      pre_q <= pre_d;
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = base_tick && (&pre_q[TAP_POS[k]:0]);
  end

  // R2: a stopped prescaler is cleared
  p_halt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && div_q == '0));

  // R1: base ticks are never back to back
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick);

  for (genvar k = 1; k < NTAP; k++) begin : g_nest
    // R3: a slower tap only fires together with every faster one
    p_tap_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tap[k] |-> tap[k-1]);
  end
endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q && !s3_q;

  // R5: one enable per edge
  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         inc,
  input  logic         wrap,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  logic [W-1:0] cnt_q;

  always_comb begin
    if (!run)      cnt_nxt = '0;
    else if (inc)  cnt_nxt = wrap ? '0 : W'(cnt_q + 1'b1);
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // R7: stopped counter reads zero
  p_stop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R4: one step per enable
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && inc && !wrap) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R4: no enable, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !inc) |=> $stable(cnt));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_run,
  input  logic             run0,
  input  logic             run1,
  input  logic [1:0]       clk_sel0,
  input  logic [1:0]       clk_sel1,
  input  logic             cascade,
  input  logic             ext_cnt,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] count0,
  output logic [CNT_W-1:0] count1,
  output logic             match0,
  output logic             match1
);
  localparam int FULL_W = 2 * CNT_W;

  logic [NTAP-1:0]   tap;
  logic              ext_rise;
  logic [1:0]        run_v, inc_v, wrap_v;
  logic [CNT_W-1:0]  cnt_v [2];
  logic [CNT_W-1:0]  nxt_v [2];
  logic [FULL_W-1:0] full_cnt, full_cmp, full_nxt;
  logic              wrap16;
  logic              match0_q, match0_d, match1_q, match1_d;

  dit_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pre_run),
    .tap   (tap)
  );

  dit_edge_sync u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_cnt),
    .rise  (ext_rise)
  );

  assign run_v = {run1, run0};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    dit_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_v[i]),
      .inc     (inc_v[i]),
      .wrap    (wrap_v[i]),
      .cnt     (cnt_v[i]),
      .cnt_nxt (nxt_v[i])
    );
  end

  assign full_cnt = {cnt_v[1], cnt_v[0]};
  assign full_cmp = {cmp1, cmp0};
  assign full_nxt = {nxt_v[1], nxt_v[0]};
  assign wrap16   = (full_cnt == full_cmp);

  always_comb begin
    case (lo_sel_e'(clk_sel0))
      LO_EXT:  inc_v[0] = ext_rise;
      LO_T1:   inc_v[0] = tap[0];
      LO_T4:   inc_v[0] = tap[1];
      default: inc_v[0] = tap[2];
    endcase

    if (cascade) begin
      wrap_v[0] = wrap16;
      wrap_v[1] = wrap16;
      inc_v[1]  = run0 && inc_v[0] && ((cnt_v[0] == '1) || wrap16);
    end else begin
      wrap_v[0] = (cnt_v[0] == cmp0);
      wrap_v[1] = (cnt_v[1] == cmp1);
      case (hi_sel_e'(clk_sel1))
        HI_MATCH: inc_v[1] = match0_q;
        HI_T1:    inc_v[1] = tap[0];
        HI_T16:   inc_v[1] = tap[2];
        default:  inc_v[1] = tap[3];
      endcase
    end

    match0_d = !cascade && run0 && inc_v[0] && (nxt_v[0] == cmp0);
    if (cascade) match1_d = run0 && inc_v[0] && (full_nxt == full_cmp);
    else         match1_d = run1 && inc_v[1] && (nxt_v[1] == cmp1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match0_q <= 1'b0;
      match1_q <= 1'b0;
    end else begin
      match0_q <= match0_d;
      match1_q <= match1_d;
    end
  end

  assign count0 = cnt_v[0];
  assign count1 = cnt_v[1];
  assign match0 = match0_q;
  assign match1 = match1_q;

  // R8: match pulses last one cycle
  p_match0_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match0 |=> !match0);
  p_match1_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match1 |=> !match1);

  // R8: 8-bit match coincides with the compare value
  p_match0_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match0 |-> (count0 == $past(cmp0)));

  // R9: low match silent in 16-bit mode
  p_cascade_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cascade |=> !match0);

  // R9: carry from low byte advances high byte
  p_cascade_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && run0 && run1 && inc_v[0] && count0 == '1 && !wrap16)
      |=> (count1 == CNT_W'($past(count1) + 1'b1) && count0 == '0));
endmodule

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_run = 1'b0, run0 = 1'b0, run1 = 1'b0, cascade = 1'b0, ext_cnt = 1'b0;
  logic [1:0] clk_sel0 = 2'b01, clk_sel1 = 2'b01;
  logic [7:0] cmp0 = 8'hFF, cmp1 = 8'hFF;
  logic [7:0] count0, count1;
  logic       match0, match1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer dut (
    .clk(clk), .rst_n(rst_n), .pre_run(pre_run), .run0(run0), .run1(run1),
    .clk_sel0(clk_sel0), .clk_sel1(clk_sel1), .cascade(cascade),
    .ext_cnt(ext_cnt), .cmp0(cmp0), .cmp1(cmp1),
    .count0(count0), .count1(count1), .match0(match0), .match1(match1));

  // behavioural reference
  int m_div = 0, m_pre = 0, m_c0 = 0, m_c1 = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0, m_m0 = 0, m_m1 = 0;

  always @(posedge clk) begin
    bit tick, t1, t4, t16, t256, ep, i0, i1, nm0, nm1;
    int n0, n1, v, c16;
    if (!rst_n) begin
      m_div = 0; m_pre = 0; m_c0 = 0; m_c1 = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_m0 = 0; m_m1 = 0;
    end else begin
      tick = pre_run && (m_div == 3);
      t1   = tick && ((m_pre + 1) % 2 == 0);
      t4   = tick && ((m_pre + 1) % 8 == 0);
      t16  = tick && ((m_pre + 1) % 32 == 0);
      t256 = tick && ((m_pre + 1) % 512 == 0);
      ep   = m_s2 && !m_s3;
      case (clk_sel0)
        2'd0: i0 = ep;
        2'd1: i0 = t1;
        2'd2: i0 = t4;
        default: i0 = t16;
      endcase
      c16 = int'(cmp1) * 256 + int'(cmp0);
      if (cascade) begin
        n0 = m_c0; n1 = m_c1;
        if (run0 && i0) begin
          v = m_c1 * 256 + m_c0;
          v = (v == c16) ? 0 : (v + 1) % 65536;
          n0 = v % 256; n1 = v / 256;
        end
        if (!run0) n0 = 0;
        if (!run1) n1 = 0;
        nm0 = 0;
        nm1 = run0 && i0 && (n1 * 256 + n0 == c16);
      end else begin
        case (clk_sel1)
          2'd0: i1 = m_m0;
          2'd1: i1 = t1;
          2'd2: i1 = t16;
          default: i1 = t256;
        endcase
        n0 = !run0 ? 0 : (i0 ? ((m_c0 == int'(cmp0)) ? 0 : (m_c0 + 1) % 256) : m_c0);
        n1 = !run1 ? 0 : (i1 ? ((m_c1 == int'(cmp1)) ? 0 : (m_c1 + 1) % 256) : m_c1);
        nm0 = run0 && i0 && (n0 == int'(cmp0));
        nm1 = run1 && i1 && (n1 == int'(cmp1));
      end
      m_div = pre_run ? (m_div + 1) % 4 : 0;
      m_pre = !pre_run ? 0 : (tick ? (m_pre + 1) % 512 : m_pre);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_cnt;
      m_c0 = n0; m_c1 = n1; m_m0 = nm0; m_m1 = nm1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(count0) == m_c0, cascade ? "R9 count0" : "R4 count0", count0, m_c0);
      chk(int'(count1) == m_c1, cascade ? "R9 count1" : "R6 count1", count1, m_c1);
      chk(match0 == m_m0, "R8 match0", match0, m_m0);
      chk(match1 == m_m1, cascade ? "R9 match1" : "R8 match1", match1, m_m1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // gap in clocks between the 2nd and 3rd match0 pulses
  task automatic gap_m0(output int gap);
    int seen = 0;
    int last = 0;
    gap = -1;
    for (int c = 0; c < 20000 && seen < 3; c++) begin
      @(negedge clk);
      if (match0) begin
        seen++;
        if (seen == 3) gap = c - last;
        last = c;
      end
    end
  endtask

  int hits0, hits1, gap, prev;

  initial begin
    cycles(4);
    // R10: reset state
    chk(count0 == 0, "R10 count0", count0, 0);
    chk(count1 == 0, "R10 count1", count1, 0);
    chk(!match0 && !match1, "R10 match", match0 | match1, 0);
    rst_n = 1'b1;

    // R2: prescaler stopped, tap-driven counter stays zero
    run0 = 1; clk_sel0 = 2'b01;
    cycles(100);
    chk(count0 == 0, "R2 halted prescaler", count0, 0);

    // R1/R3: tap periods through match0 with compare 0
    pre_run = 1; cmp0 = 8'd0;
    gap_m0(gap); chk(gap == 8, "R1 T1 period", gap, 8);
    clk_sel0 = 2'b10;
    gap_m0(gap); chk(gap == 32, "R3 T4 period", gap, 32);
    clk_sel0 = 2'b11;
    gap_m0(gap); chk(gap == 128, "R3 T16 period", gap, 128);

    // R8: wrap at small compare
    clk_sel0 = 2'b01; cmp0 = 8'd3;
    cycles(200);

    // R5: external edge latency
    run0 = 0; cycles(2); run0 = 1; clk_sel0 = 2'b00; cmp0 = 8'hFF;
    cycles(3);
    prev = count0;
    ext_cnt = 1;
    cycles(2);
    chk(count0 == prev, "R5 not before third edge", count0, prev);
    cycles(1);
    chk(count0 == prev + 1, "R5 third edge", count0, prev + 1);
    cycles(3); ext_cnt = 0; cycles(4);
    for (int k = 0; k < 12; k++) begin
      ext_cnt = 1; cycles(1 + k % 3); ext_cnt = 0; cycles(2 + k % 2);
    end
    chk(count0 == prev + 13, "R5 edge count", count0, prev + 13);
    cmp0 = 8'd4;
    for (int k = 0; k < 10; k++) begin
      ext_cnt = 1; cycles(3); ext_cnt = 0; cycles(3);
    end

    // R6: high counter from match0, then from each tap
    clk_sel0 = 2'b01; cmp0 = 8'd2; run1 = 1; clk_sel1 = 2'b00; cmp1 = 8'd3;
    cycles(400);
    clk_sel1 = 2'b01; cmp1 = 8'd5;
    cycles(300);
    clk_sel1 = 2'b10; cmp1 = 8'd2;
    cycles(500);
    clk_sel1 = 2'b11; cmp1 = 8'd1;
    cycles(6000);

    // R7: stopped high counter
    run1 = 0; cycles(1);
    chk(count1 == 0, "R7 run1 clear", count1, 0);
    cycles(50);
    chk(count1 == 0, "R7 run1 held", count1, 0);

    // R9: 16-bit mode
    run1 = 1; run0 = 0; cycles(1); run0 = 1;
    cascade = 1; clk_sel0 = 2'b01; cmp0 = 8'h02; cmp1 = 8'h01;
    hits0 = 0; hits1 = 0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (match0) hits0++;
      if (match1) hits1++;
    end
    chk(hits1 >= 2, "R9 16-bit match seen", hits1, 2);
    chk(hits0 == 0, "R9 match0 quiet", hits0, 0);

    // R2: prescaler stop mid-run
    pre_run = 0; cycles(1); prev = count0; cycles(40);
    chk(count0 == prev, "R2 stop freezes counter", count0, prev);
    pre_run = 1; cascade = 0; cycles(300);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule